// File: doc/BRIEF.md
# First/Next Error Capture Logger

This block collects error strobes from six downstream ports, numbered 2 to 7, and keeps a record of them in two status registers. The first-error register holds the single port whose error arrived while that register was empty. The next-error register collects every later error, port by port. A snapshot of the port number and a free-running timestamp is taken only when the first-error register captures. That snapshot therefore describes the error that started an incident, and later errors do not overwrite it.

Both status registers and the snapshot are sticky. A warm reset leaves them untouched as long as power-good stays high, so firmware can inspect them after a reboot. They return to zero only when power-good drops, or when software writes a one to clear an individual bit. Ports are grouped into two clusters: ports 2–3 and ports 4–7. Each cluster drives a level error pin that stays high while any recorded bit in that cluster is set.

Software reaches the registers through a single-cycle read/write port. It selects a register kind and a port number. Read data is combinational.

Top module: `errlog_top`

## Requirements
- R1: Strobe bit i stands for port 2+i. When the first-error register is empty and one or more strobes are high at a clock edge, only the lowest-numbered strobed port is set in the first-error register. Every other strobed port is set in the next-error register.
- R2: The first-error register never holds more than one set bit. While it is non-zero, new errors do not change it. It holds its bit until a write-one-to-clear reaches that bit.
- R3: A strobe that arrives while the first-error register is non-zero sets the next-error bit of that port, including the port that holds the first error.
- R4: A write (reg_wr high) with reg_sel 0 (first) or 1 (next), reg_port in 2..7 and reg_wdata bit 0 high clears the selected bit at the clock edge. If reg_wdata bit 0 is low, the write has no effect. If the same bit is being set in the same cycle, it stays set.
- R5: A low warm_rst_n leaves the first-error register, the next-error register and the snapshot unchanged. A low pwr_good clears all of them at once, and log_valid goes low.
- R6: The snapshot (log_valid, log_port, log_time) changes only at a clock edge where the first-error register captures. At that edge it stores the captured port number and the timestamp value of that cycle. Errors that go only to the next-error register leave it unchanged.
- R7: The timestamp is 0 while warm_rst_n or pwr_good is low and increases by one at every clock edge after that, modulo 2^16. An error sampled at the n-th edge after reset release therefore logs n-1.
- R8: err_pin[0] is high exactly while any first-error or next-error bit of ports 2–3 is set, and err_pin[1] does the same for ports 4–7. Both pins follow the registers in the cycle after each capture or clear.
- R9: reg_rdata is combinational. For reg_sel 0 or 1, bit 0 is the status of port reg_port and bits 31:1 read 0. For reg_sel 2 it holds log_time in bits 15:0, log_port in bits 18:16 and log_valid in bit 19, with zeros above. For reg_sel 3, or for a port number outside 2..7, it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| warm_rst_n | input | 1 | Warm reset, active low; restarts the timestamp only |
| pwr_good | input | 1 | Power-good; low clears all sticky state asynchronously |
| err_strobe | input | 6 | Per-port error strobes, bit i is port 2+i |
| reg_wr | input | 1 | Write-one-to-clear strobe |
| reg_sel | input | 2 | Register kind: 0 first, 1 next, 2 snapshot, 3 none |
| reg_port | input | 3 | Port number addressed by read or write |
| reg_wdata | input | 32 | Write data; bit 0 requests the clear |
| reg_rdata | output | 32 | Read data for reg_sel/reg_port |
| first_vec | output | 6 | First-error register, bit i is port 2+i |
| next_vec | output | 6 | Next-error register, bit i is port 2+i |
| log_valid | output | 1 | Snapshot holds a captured first error |
| log_port | output | 3 | Port number of the captured first error |
| log_time | output | 16 | Timestamp of the captured first error |
| err_pin | output | 2 | Cluster error levels: bit 0 ports 2–3, bit 1 ports 4–7 |

## Verification
The bench uses the default build: six ports from 2 to 7, a cluster boundary at port 4 and a 16-bit timestamp. With six ports, all 63 non-zero strobe patterns can be driven into an empty first-error register. The bench then drives all 63 patterns again behind a first error parked on each of the six ports, so every priority pick, every next-error routing and both cluster pins are covered completely. The small port count also leaves room for directed runs on same-cycle clears, warm reset and power-good loss.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

  typedef enum logic [1:0] {
    SEL_FIRST = 2'd0,
    SEL_NEXT  = 2'd1,
    SEL_LOG   = 2'd2,
    SEL_NONE  = 2'd3
  } errlog_sel_e;

  // Isolates the least significant set bit of a vector.
  function automatic logic [31:0] lowest_onehot(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

  // Bit i set when port (base+i) belongs to cluster cl (0 below split, 1 at or above).
  function automatic logic [31:0] cluster_mask(input int base, input int nports,
                                               input int split, input int cl);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < nports; i++) begin
      if ((((base + i) >= split) ? 1 : 0) == cl) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/errlog_router.sv
module errlog_router
  import errlog_pkg::*;
#(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     err_strobe,
  input  logic             first_empty,
  output logic [N-1:0]     first_set,
  output logic [N-1:0]     next_set,
  output logic             first_capture,
  output logic [IDX_W-1:0] capture_idx
);

  logic [N-1:0] pick;

  assign pick          = N'(lowest_onehot(32'(err_strobe)));
  assign first_capture = first_empty && (err_strobe != '0);
  assign first_set     = first_capture ? pick : '0;
  assign next_set      = err_strobe & ~first_set;

  always_comb begin
    capture_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pick[i]) capture_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/errlog_sticky.sv
module errlog_sticky #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         pwr_good,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic b;
    // set wins over clear so an event in the clearing cycle is kept
    always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good)       b <= 1'b0;
      else if (set_vec[i]) b <= 1'b1;
      else if (clr_vec[i]) b <= 1'b0;
    end
    assign q[i] = b;
  end

endmodule

// File: rtl/errlog_snap.sv
module errlog_snap #(
  parameter int PORT_W = 3,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              warm_rst_n,
  input  logic              pwr_good,
  input  logic              capture,
  input  logic [PORT_W-1:0] capture_port,
  output logic              log_valid,
  output logic [PORT_W-1:0] log_port,
  output logic [TS_W-1:0]   log_time
);

  logic            ts_rst_n;
  logic [TS_W-1:0] ts;

  assign ts_rst_n = warm_rst_n & pwr_good;

  always_ff @(posedge clk or negedge ts_rst_n) begin
    if (!ts_rst_n) ts <= '0;
    else           ts <= ts + TS_W'(1);
  end

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      log_valid <= 1'b0;
      log_port  <= '0;
      log_time  <= '0;
    end else if (capture) begin
      log_valid <= 1'b1;
      log_port  <= capture_port;
      log_time  <= ts;
    end
  end

endmodule

// File: rtl/errlog_top.sv
module errlog_top
  import errlog_pkg::*;
#(
  parameter int NUM_PORTS     = 6,
  parameter int PORT_BASE     = 2,
  parameter int CLUSTER_SPLIT = 4,
  parameter int PORT_W        = 3,
  parameter int TS_W          = 16,
  parameter int DATA_W        = 32
) (
  input  logic                 clk,
  input  logic                 warm_rst_n,
  input  logic                 pwr_good,
  input  logic [NUM_PORTS-1:0] err_strobe,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_sel,
  input  logic [PORT_W-1:0]    reg_port,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_PORTS-1:0] first_vec,
  output logic [NUM_PORTS-1:0] next_vec,
  output logic                 log_valid,
  output logic [PORT_W-1:0]    log_port,
  output logic [TS_W-1:0]      log_time,
  output logic [1:0]           err_pin
);

  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int NUM_CLUSTERS = 2;
  localparam logic [PORT_W-1:0] BASE_P = PORT_W'(PORT_BASE);
  localparam logic [PORT_W-1:0] LAST_P = PORT_W'(PORT_BASE + NUM_PORTS - 1);

  // named internal events, also watched by the checker
  logic [NUM_PORTS-1:0] first_set, next_set;
  logic [NUM_PORTS-1:0] clr_first, clr_next;
  logic [NUM_PORTS-1:0] port_onehot;
  logic                 first_capture;
  logic [IDX_W-1:0]     capture_idx;
  logic [PORT_W-1:0]    capture_port;
  logic                 port_ok;
  logic [IDX_W-1:0]     idx;
  logic                 wr_bit;
  logic                 unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:1];

  errlog_router #(.N(NUM_PORTS), .IDX_W(IDX_W)) u_router (
    .err_strobe    (err_strobe),
    .first_empty   (first_vec == '0),
    .first_set     (first_set),
    .next_set      (next_set),
    .first_capture (first_capture),
    .capture_idx   (capture_idx)
  );

  // register addressing and write-one-to-clear decode
  assign port_ok     = (reg_port >= BASE_P) && (reg_port <= LAST_P);
  assign idx         = IDX_W'(reg_port - BASE_P);
  assign port_onehot = NUM_PORTS'(1) << idx;
  assign wr_bit      = reg_wr && port_ok && reg_wdata[0];
  assign clr_first   = (wr_bit && (reg_sel == SEL_FIRST)) ? port_onehot : '0;
  assign clr_next    = (wr_bit && (reg_sel == SEL_NEXT))  ? port_onehot : '0;

  errlog_sticky #(.N(NUM_PORTS)) u_first (
    .clk      (clk),
    .pwr_good (pwr_good),
    .set_vec  (first_set),
    .clr_vec  (clr_first),
    .q        (first_vec)
  );

  errlog_sticky #(.N(NUM_PORTS)) u_next (
    .clk      (clk),
    .pwr_good (pwr_good),
    .set_vec  (next_set),
    .clr_vec  (clr_next),
    .q        (next_vec)
  );

  assign capture_port = BASE_P + PORT_W'(capture_idx);

  errlog_snap #(.PORT_W(PORT_W), .TS_W(TS_W)) u_snap (
    .clk          (clk),
    .warm_rst_n   (warm_rst_n),
    .pwr_good     (pwr_good),
    .capture      (first_capture),
    .capture_port (capture_port),
    .log_valid    (log_valid),
    .log_port     (log_port),
    .log_time     (log_time)
  );

  // cluster error levels
  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_pin
    localparam logic [NUM_PORTS-1:0] MASK =
      NUM_PORTS'(cluster_mask(PORT_BASE, NUM_PORTS, CLUSTER_SPLIT, c));
    assign err_pin[c] = |((first_vec | next_vec) & MASK);
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (errlog_sel_e'(reg_sel))
      SEL_FIRST: if (port_ok) reg_rdata[0] = first_vec[idx];
      SEL_NEXT:  if (port_ok) reg_rdata[0] = next_vec[idx];
      SEL_LOG: begin
        reg_rdata[TS_W-1:0]       = log_time;
        reg_rdata[TS_W +: PORT_W] = log_port;
        reg_rdata[TS_W + PORT_W]  = log_valid;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/errlog_chk.sv
module errlog_chk #(
  parameter int N      = 6,
  parameter int PORT_W = 3,
  parameter int TS_W   = 16
) (
  input logic              clk,
  input logic              pwr_good,
  input logic [N-1:0]      err_strobe,
  input logic [N-1:0]      first_vec,
  input logic [N-1:0]      next_vec,
  input logic [N-1:0]      clr_first,
  input logic [N-1:0]      clr_next,
  input logic              first_capture,
  input logic              log_valid,
  input logic [PORT_W-1:0] log_port,
  input logic [TS_W-1:0]   log_time,
  input logic [1:0]        err_pin
);

  assert_pick_lowest_R1: assert property (@(posedge clk) disable iff (!pwr_good)
    (first_vec == '0 && err_strobe != '0) |=>
      ($onehot(first_vec) && (((first_vec - N'(1)) & $past(err_strobe)) == '0)));

  assert_first_onehot_R2: assert property (@(posedge clk) disable iff (!pwr_good)
    $onehot0(first_vec));

  assert_first_hold_R2: assert property (@(posedge clk) disable iff (!pwr_good)
    (first_vec != '0) |=> (first_vec == ($past(first_vec) & ~$past(clr_first))));

  assert_next_record_R3: assert property (@(posedge clk) disable iff (!pwr_good)
    (first_vec != '0) |=> ((next_vec & $past(err_strobe)) == $past(err_strobe)));

  assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!pwr_good)
    (first_vec != '0 && (err_strobe & clr_next) != '0) |=>
      ((next_vec & $past(err_strobe & clr_next)) == $past(err_strobe & clr_next)));

  assert_log_stable_R6: assert property (@(posedge clk) disable iff (!pwr_good)
    !first_capture |=> ($stable(log_port) && $stable(log_time) && $stable(log_valid)));

  assert_pin_follows_R8: assert property (@(posedge clk) disable iff (!pwr_good)
    (err_strobe != '0) |=> (err_pin != 2'b00));

endmodule

bind errlog_top errlog_chk #(.N(NUM_PORTS), .PORT_W(PORT_W), .TS_W(TS_W)) u_chk (
  .clk           (clk),
  .pwr_good      (pwr_good),
  .err_strobe    (err_strobe),
  .first_vec     (first_vec),
  .next_vec      (next_vec),
  .clr_first     (clr_first),
  .clr_next      (clr_next),
  .first_capture (first_capture),
  .log_valid     (log_valid),
  .log_port      (log_port),
  .log_time      (log_time),
  .err_pin       (err_pin)
);

// File: tb/errlog_top_tb.sv
module errlog_top_tb;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        warm_rst_n = 1'b0;
  logic        pwr_good = 1'b0;
  logic [N-1:0] err_strobe = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [2:0]  reg_port = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] first_vec, next_vec;
  logic        log_valid;
  logic [2:0]  log_port;
  logic [15:0] log_time;
  logic [1:0]  err_pin;

  int total = 0;
  int bad = 0;
  logic [15:0] tb_ts = '0;

  always #10 clk = ~clk;

  // bench view of R7: zero while held in reset, +1 per edge afterwards
  always @(posedge clk) begin
    if (!warm_rst_n || !pwr_good) tb_ts <= '0;
    else                          tb_ts <= tb_ts + 16'd1;
  end

  errlog_top u_dut (
    .clk(clk), .warm_rst_n(warm_rst_n), .pwr_good(pwr_good),
    .err_strobe(err_strobe), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_port(reg_port), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .first_vec(first_vec), .next_vec(next_vec), .log_valid(log_valid),
    .log_port(log_port), .log_time(log_time), .err_pin(err_pin)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input int port, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_port = 3'(port); reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_all();
    for (int p = 2; p < 8; p++) begin
      wr(2'd0, p, 32'd1);
      wr(2'd1, p, 32'd1);
    end
  endtask

  task automatic pulse(input logic [N-1:0] pat, output logic [15:0] ts);
    err_strobe = pat;
    ts = tb_ts;
    tick();
    err_strobe = '0;
  endtask

  task automatic rd(input logic [1:0] s, input int port, output logic [31:0] d);
    reg_sel = s; reg_port = 3'(port);
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [N-1:0] low_bit(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic int port_of(input logic [N-1:0] oh);
    for (int i = 0; i < N; i++) if (oh[i]) return 2 + i;
    return 0;
  endfunction

  function automatic logic [1:0] pins(input logic [N-1:0] v);
    return {|v[5:2], |v[1:0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements): actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] ts0, ts1;
    logic [31:0] d;
    logic [N-1:0] lo;

    repeat (3) @(negedge clk);
    pwr_good = 1'b1;
    @(negedge clk);
    warm_rst_n = 1'b1;
    tick();

    // reset state
    chk("R5", "reset first_vec", 32'(first_vec), 32'd0);
    chk("R5", "reset next_vec", 32'(next_vec), 32'd0);
    chk("R5", "reset log_valid", 32'(log_valid), 32'd0);
    chk("R8", "reset err_pin", 32'(err_pin), 32'd0);
    rd(2'd2, 0, d);
    chk("R9", "reset snapshot read", d, 32'd0);

    // sweep: every pattern into an empty first register
    for (int pat = 1; pat < 64; pat++) begin
      clear_all();
      chk("R4", "cleared first", 32'(first_vec), 32'd0);
      chk("R8", "pins after clear", 32'(err_pin), 32'd0);
      lo = low_bit(N'(pat));
      pulse(N'(pat), ts0);
      chk("R1", $sformatf("first pat=%0d", pat), 32'(first_vec), 32'(lo));
      chk("R1", $sformatf("next pat=%0d", pat), 32'(next_vec), 32'(N'(pat) & ~lo));
      chk("R6", "log_valid", 32'(log_valid), 32'd1);
      chk("R6", "log_port", 32'(log_port), 32'(port_of(lo)));
      chk("R7", "log_time", 32'(log_time), 32'(ts0));
      chk("R8", "err_pin", 32'(err_pin), 32'(pins(N'(pat))));
      rd(2'd2, 0, d);
      chk("R9", "snapshot read", d, (32'd1 << 19) | (32'(port_of(lo)) << 16) | 32'(ts0));
      rd(2'd0, port_of(lo), d);
      chk("R9", "first read", d, 32'd1);
    end

    // sweep: every pattern behind a first error on each port
    for (int p = 0; p < N; p++) begin
      for (int pat = 1; pat < 64; pat++) begin
        clear_all();
        pulse(N'(1) << p, ts0);
        pulse(N'(pat), ts1);
        chk("R2", $sformatf("first held p=%0d pat=%0d", p, pat), 32'(first_vec), 32'(N'(1) << p));
        chk("R3", $sformatf("next p=%0d pat=%0d", p, pat), 32'(next_vec), 32'(pat));
        chk("R6", "log_port unchanged", 32'(log_port), 32'(p + 2));
        chk("R6", "log_time unchanged", 32'(log_time), 32'(ts0));
        chk("R8", "err_pin", 32'(err_pin), 32'(pins((N'(1) << p) | N'(pat))));
      end
    end

    // R4 directed: clear semantics
    clear_all();
    pulse(6'b000001, ts0);
    pulse(6'b001000, ts1);
    wr(2'd0, 2, 32'hFFFF_FFFE);
    chk("R4", "wdata bit0 low keeps first", 32'(first_vec), 32'h01);
    reg_wr = 1'b1; reg_sel = 2'd1; reg_port = 3'd5; reg_wdata = 32'd1;
    err_strobe = 6'b001000;
    tick();
    reg_wr = 1'b0; err_strobe = '0;
    chk("R4", "set beats clear on next", 32'(next_vec), 32'h08);
    wr(2'd1, 5, 32'd1);
    chk("R4", "plain clear of next", 32'(next_vec), 32'h00);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_port = 3'd2; reg_wdata = 32'd1;
    err_strobe = 6'b010000;
    tick();
    reg_wr = 1'b0; err_strobe = '0;
    chk("R4", "first cleared", 32'(first_vec), 32'h00);
    chk("R3", "strobe during clear goes to next", 32'(next_vec), 32'h10);
    chk("R6", "log_port kept", 32'(log_port), 32'd2);
    pulse(6'b100000, ts1);
    chk("R1", "recapture first", 32'(first_vec), 32'h20);
    chk("R6", "log_port recaptured", 32'(log_port), 32'd7);
    chk("R6", "log_time recaptured", 32'(log_time), 32'(ts1));

    // R9 reads
    rd(2'd0, 7, d); chk("R9", "first port7", d, 32'd1);
    rd(2'd1, 6, d); chk("R9", "next port6", d, 32'd1);
    rd(2'd0, 2, d); chk("R9", "first port2", d, 32'd0);
    rd(2'd0, 1, d); chk("R9", "port1 out of range", d, 32'd0);
    rd(2'd1, 0, d); chk("R9", "port0 out of range", d, 32'd0);
    rd(2'd3, 7, d); chk("R9", "sel none", d, 32'd0);
    wr(2'd0, 1, 32'd1);
    chk("R4", "write to port1 ignored", 32'(first_vec), 32'h20);

    // R5 warm reset keeps state
    warm_rst_n = 1'b0;
    repeat (3) tick();
    chk("R5", "warm first kept", 32'(first_vec), 32'h20);
    chk("R5", "warm next kept", 32'(next_vec), 32'h10);
    chk("R5", "warm log_port kept", 32'(log_port), 32'd7);
    chk("R5", "warm log_valid kept", 32'(log_valid), 32'd1);
    chk("R8", "warm pins kept", 32'(err_pin), 32'b10);
    warm_rst_n = 1'b1;

    // R7 timestamp restart
    clear_all();
    warm_rst_n = 1'b0;
    repeat (2) tick();
    warm_rst_n = 1'b1;
    repeat (5) tick();
    pulse(6'b000010, ts0);
    chk("R7", "timestamp after warm reset", 32'(log_time), 32'd5);
    chk("R8", "pin cluster0", 32'(err_pin), 32'b01);

    // R5 power-good loss
    pulse(6'b000100, ts1);
    pwr_good = 1'b0;
    #1;
    chk("R5", "pgood first cleared", 32'(first_vec), 32'd0);
    chk("R5", "pgood next cleared", 32'(next_vec), 32'd0);
    chk("R5", "pgood log_valid cleared", 32'(log_valid), 32'd0);
    chk("R8", "pgood pins low", 32'(err_pin), 32'd0);
    tick();
    pwr_good = 1'b1;
    tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule